// File: doc/BRIEF.md
# Dual-ALU Fixed-Point Processing Element

This block is one processing element of a two-dimensional SIMD image array. Each cycle it accepts one decoded operation bundle. A bundle can drive two independent integer ALUs and one multiply-accumulate unit at the same time. All three units take their operands from a 16-entry, 16-bit register file that is local to the element. The datapath works either on full 16-bit words or on two packed 8-bit lanes. Floating point is not supported.

Every result is produced in a single cycle. Results are written into the register file at the clock edge that samples the bundle. At that same edge they are mirrored onto three registered write-back ports, so they are visible in the following cycle. A word arriving from a neighbouring element can be moved into a register. A selectable register is exposed combinationally for the neighbour shift path.

The bundle input has no ready signal. The element never stalls. A bundle presented with `issue` high is consumed in that cycle. A bundle presented with `issue` low does nothing, and neither does one with the predicate low.

Top module: `pe_dual_alu`

## Requirements
- R1: After reset every register reads 0 on `nbr_out`, the accumulator is 0 and all three write-back enables are low.
- R2: In 16-bit mode an ALU computes, by 4-bit opcode: 0 add, 1 subtract (both wrap), 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 arithmetic shift right (shift amount is b[3:0]), 8 signed min, 9 signed max, 10 absolute difference of signed operands, 12 signed less-than (gives 1 or 0). Codes 13 to 15 give 0. The result appears on that ALU's write-back port one cycle after issue and is stored in the destination register.
- R3: With `byte_mode` high, each opcode of R2 works on bits [7:0] and [15:8] independently. No carry or borrow crosses the lanes, shift amounts come from each lane's b[2:0], and less-than gives 1 per lane.
- R4: Opcode 11 copies `nbr_in` to the destination, whatever the mode.
- R5: ALU0, ALU1 and the MAC can all write in the same cycle. Every operand reads the register values from before that cycle's edge.
- R6: The MAC product is the signed 16x16 product. In byte mode it is the sum of the two signed lane products. With `mac_clr` high the 32-bit accumulator is loaded with the product; otherwise the product is added with 32-bit wrap.
- R7: The MAC writes the new accumulator value, saturated to the signed 16-bit range (0x7FFF / 0x8000), to `mac_dst`.
- R8: When units target the same register in one cycle, the MAC wins over ALU0, and ALU0 wins over ALU1. A losing unit writes nothing and its write-back enable stays low.
- R9: If `issue` or `pred` is low, no register or accumulator changes and all write-back enables are low in the next cycle.
- R10: `nbr_out` shows the current content of the register selected by `nbr_sel`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Bundle present this cycle |
| pred | input | 1 | Predicate; low suppresses all writes |
| byte_mode | input | 1 | 1: two packed 8-bit lanes, 0: 16-bit |
| alu0_en | input | 1 | ALU0 active |
| alu0_op | input | 4 | ALU0 opcode |
| alu0_dst | input | 4 | ALU0 destination register |
| alu0_src_a | input | 4 | ALU0 operand A register |
| alu0_src_b | input | 4 | ALU0 operand B register |
| alu1_en | input | 1 | ALU1 active |
| alu1_op | input | 4 | ALU1 opcode |
| alu1_dst | input | 4 | ALU1 destination register |
| alu1_src_a | input | 4 | ALU1 operand A register |
| alu1_src_b | input | 4 | ALU1 operand B register |
| mac_en | input | 1 | MAC active |
| mac_clr | input | 1 | Load product instead of accumulating |
| mac_dst | input | 4 | MAC destination register |
| mac_src_a | input | 4 | MAC operand A register |
| mac_src_b | input | 4 | MAC operand B register |
| nbr_in | input | 16 | Word shifted in from a neighbour |
| nbr_sel | input | 4 | Register exposed on nbr_out |
| wb_alu0_en | output | 1 | ALU0 wrote last cycle |
| wb_alu0_idx | output | 4 | ALU0 written register |
| wb_alu0_data | output | 16 | ALU0 written value |
| wb_alu1_en | output | 1 | ALU1 wrote last cycle |
| wb_alu1_idx | output | 4 | ALU1 written register |
| wb_alu1_data | output | 16 | ALU1 written value |
| wb_mac_en | output | 1 | MAC wrote last cycle |
| wb_mac_idx | output | 4 | MAC written register |
| wb_mac_data | output | 16 | Saturated accumulator value written |
| nbr_out | output | 16 | Register value for the neighbour shift path |

## Verification
The hardest overlaps are ALU and MAC write-backs landing in one cycle. These include two or three units aimed at the same register, and a unit reading a register that another unit overwrites at that same edge. Random bundles draw their register indices from a small pool, so destination clashes and read-after-write in one cycle happen often. Directed bundles also send all three units at one register. A bench model applies the priority order, checks which write-back enables survive, and compares every register seen on `nbr_out` against its expected value.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int RF_DEPTH = 16;
  localparam int ACC_W = 32;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_SRA  = 4'd7,
    OP_MIN  = 4'd8,
    OP_MAX  = 4'd9,
    OP_ABSD = 4'd10,
    OP_NBR  = 4'd11,
    OP_CMPLT = 4'd12,
    OP_RSV13 = 4'd13,
    OP_RSV14 = 4'd14,
    OP_RSV15 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/pe_regfile.sv
module pe_regfile #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int NRD    = 7,
  parameter int NWR    = 3,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NWR-1:0]               wr_en,
  input  logic [NWR-1:0][AW-1:0]       wr_addr,
  input  logic [NWR-1:0][DATA_W-1:0]   wr_data,
  input  logic [NRD-1:0][AW-1:0]       rd_addr,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Write ports are disjoint in address (the top resolves clashes);
  // higher port index is applied last.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else begin
      for (int p = 0; p < NWR; p++)
        if (wr_en[p]) mem[wr_addr[p]] <= wr_data[p];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = mem[rd_addr[r]];
  end

  for (genvar w = 0; w < NWR; w++) begin : g_chk
    // R5: every granted write is found in the file after the edge
    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[w] |=> mem[$past(wr_addr[w])] == $past(wr_data[w]));
  end
endmodule

// File: rtl/pe_lane.sv
module pe_lane
  import pe_pkg::*;
#(
  parameter int W = 16,
  localparam int SW = $clog2(W)
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  logic [SW-1:0] sh;
  logic [W:0]    diff, ndiff;
  logic          lt;

  assign sh    = b[SW-1:0];
  assign diff  = {a[W-1], a} - {b[W-1], b};
  assign ndiff = -diff;
  assign lt    = $signed(a) < $signed(b);

  always_comb begin
    unique case (op)
      OP_ADD:   y = a + b;
      OP_SUB:   y = a - b;
      OP_AND:   y = a & b;
      OP_OR:    y = a | b;
      OP_XOR:   y = a ^ b;
      OP_SHL:   y = a << sh;
      OP_SHR:   y = a >> sh;
      OP_SRA:   y = $unsigned($signed(a) >>> sh);
      OP_MIN:   y = lt ? a : b;
      OP_MAX:   y = lt ? b : a;
      OP_ABSD:  y = diff[W] ? ndiff[W-1:0] : diff[W-1:0];
      OP_CMPLT: y = {{(W-1){1'b0}}, lt};
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/pe_alu.sv
module pe_alu
  import pe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  alu_op_e            op,
  input  logic               byte_mode,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  logic [DATA_W-1:0]  nbr,
  output logic [DATA_W-1:0]  y
);
  logic [DATA_W-1:0] y_full, y_pack;

  pe_lane #(.W(DATA_W)) u_full (.op(op), .a(a), .b(b), .y(y_full));

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    pe_lane #(.W(LANE_W)) u_lane (
      .op(op),
      .a(a[l*LANE_W +: LANE_W]),
      .b(b[l*LANE_W +: LANE_W]),
      .y(y_pack[l*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    if (op == OP_NBR)  y = nbr;
    else if (byte_mode) y = y_pack;
    else                y = y_full;
  end

  // R3: packed add keeps the low lane free of any high-lane influence
  p_lane_iso_r3: assert final (!(byte_mode && op == OP_ADD) ||
    y[LANE_W-1:0] == LANE_W'(a[LANE_W-1:0] + b[LANE_W-1:0]));
endmodule

// File: rtl/pe_mac.sv
module pe_mac #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int ACC_W  = 32,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic               clr,
  input  logic               byte_mode,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  output logic [DATA_W-1:0]  sat_nxt
);
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'(2**(DATA_W-1) - 1);
  localparam logic signed [ACC_W-1:0] SMIN = -ACC_W'(2**(DATA_W-1));

  logic signed [ACC_W-1:0] acc_q, acc_nxt, prod, prod_full, prod_pack;
  logic signed [ACC_W-1:0] lane_p [NLANE];

  assign prod_full = ACC_W'($signed(a) * $signed(b));

  for (genvar l = 0; l < NLANE; l++) begin : g_lp
    assign lane_p[l] = ACC_W'($signed(a[l*LANE_W +: LANE_W]) *
                              $signed(b[l*LANE_W +: LANE_W]));
  end

  always_comb begin
    prod_pack = '0;
    for (int l = 0; l < NLANE; l++) prod_pack = prod_pack + lane_p[l];
  end

  assign prod    = byte_mode ? prod_pack : prod_full;
  assign acc_nxt = clr ? prod : acc_q + prod;

  always_comb begin
    if (acc_nxt > SMAX)      sat_nxt = SMAX[DATA_W-1:0];
    else if (acc_nxt < SMIN) sat_nxt = SMIN[DATA_W-1:0];
    else                     sat_nxt = acc_nxt[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (upd) acc_q <= acc_nxt;
  end

  // R9: accumulator frozen whenever no enabled MAC issue
  p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(acc_q));
  // R6: clear loads the bare product
  p_clr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && clr) |=> acc_q == $past(prod));
endmodule

// File: rtl/pe_dual_alu.sv
module pe_dual_alu
  import pe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic        pred,
  input  logic        byte_mode,
  input  logic        alu0_en,
  input  logic [3:0]  alu0_op,
  input  logic [3:0]  alu0_dst,
  input  logic [3:0]  alu0_src_a,
  input  logic [3:0]  alu0_src_b,
  input  logic        alu1_en,
  input  logic [3:0]  alu1_op,
  input  logic [3:0]  alu1_dst,
  input  logic [3:0]  alu1_src_a,
  input  logic [3:0]  alu1_src_b,
  input  logic        mac_en,
  input  logic        mac_clr,
  input  logic [3:0]  mac_dst,
  input  logic [3:0]  mac_src_a,
  input  logic [3:0]  mac_src_b,
  input  logic [15:0] nbr_in,
  input  logic [3:0]  nbr_sel,
  output logic        wb_alu0_en,
  output logic [3:0]  wb_alu0_idx,
  output logic [15:0] wb_alu0_data,
  output logic        wb_alu1_en,
  output logic [3:0]  wb_alu1_idx,
  output logic [15:0] wb_alu1_data,
  output logic        wb_mac_en,
  output logic [3:0]  wb_mac_idx,
  output logic [15:0] wb_mac_data,
  output logic [15:0] nbr_out
);
  localparam int AW  = $clog2(RF_DEPTH);
  localparam int NRD = 7;
  localparam int NWR = 3;

  logic [NRD-1:0][AW-1:0]     rd_addr;
  logic [NRD-1:0][DATA_W-1:0] rd_data;
  logic [NWR-1:0]             wr_en;
  logic [NWR-1:0][AW-1:0]     wr_addr;
  logic [NWR-1:0][DATA_W-1:0] wr_data;
  logic [DATA_W-1:0]          y0, y1, ym;
  logic                       go, g_mac, g0, g1;

  assign rd_addr = {nbr_sel, mac_src_b, mac_src_a,
                    alu1_src_b, alu1_src_a, alu0_src_b, alu0_src_a};

  pe_regfile #(.DEPTH(RF_DEPTH), .DATA_W(DATA_W), .NRD(NRD), .NWR(NWR)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  pe_alu #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_alu0 (
    .op(alu_op_e'(alu0_op)), .byte_mode(byte_mode),
    .a(rd_data[0]), .b(rd_data[1]), .nbr(nbr_in), .y(y0)
  );

  pe_alu #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_alu1 (
    .op(alu_op_e'(alu1_op)), .byte_mode(byte_mode),
    .a(rd_data[2]), .b(rd_data[3]), .nbr(nbr_in), .y(y1)
  );

  // write grants: MAC > ALU0 > ALU1
  assign go    = issue && pred;
  assign g_mac = go && mac_en;
  assign g0    = go && alu0_en && !(g_mac && mac_dst == alu0_dst);
  assign g1    = go && alu1_en && !(g_mac && mac_dst == alu1_dst)
                               && !(g0 && alu0_dst == alu1_dst);

  pe_mac #(.DATA_W(DATA_W), .LANE_W(LANE_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .upd(g_mac), .clr(mac_clr),
    .byte_mode(byte_mode), .a(rd_data[4]), .b(rd_data[5]), .sat_nxt(ym)
  );

  assign wr_en   = {g_mac, g1, g0};
  assign wr_addr = {mac_dst, alu1_dst, alu0_dst};
  assign wr_data = {ym, y1, y0};
  assign nbr_out = rd_data[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_alu0_en <= 1'b0; wb_alu0_idx <= '0; wb_alu0_data <= '0;
      wb_alu1_en <= 1'b0; wb_alu1_idx <= '0; wb_alu1_data <= '0;
      wb_mac_en  <= 1'b0; wb_mac_idx  <= '0; wb_mac_data  <= '0;
    end else begin
      wb_alu0_en <= g0;    wb_alu0_idx <= alu0_dst; wb_alu0_data <= y0;
      wb_alu1_en <= g1;    wb_alu1_idx <= alu1_dst; wb_alu1_data <= y1;
      wb_mac_en  <= g_mac; wb_mac_idx  <= mac_dst;  wb_mac_data  <= ym;
    end
  end

  // R9: a dead bundle reports no write-back
  p_pred_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && pred) |=> !(wb_alu0_en || wb_alu1_en || wb_mac_en));
  // R8: MAC beats ALU0 on a shared destination
  p_mac_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && pred && mac_en && alu0_en && mac_dst == alu0_dst)
      |=> (wb_mac_en && !wb_alu0_en));
  // R8: no two reported write-backs name the same register
  p_distinct_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_alu0_en && wb_alu1_en) |-> wb_alu0_idx != wb_alu1_idx);
endmodule

// File: tb/pe_dual_alu_tb_top.sv
module pe_dual_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue, pred, byte_mode;
  logic alu0_en, alu1_en, mac_en, mac_clr;
  logic [3:0] alu0_op, alu0_dst, alu0_src_a, alu0_src_b;
  logic [3:0] alu1_op, alu1_dst, alu1_src_a, alu1_src_b;
  logic [3:0] mac_dst, mac_src_a, mac_src_b, nbr_sel;
  logic [15:0] nbr_in;
  logic wb_alu0_en, wb_alu1_en, wb_mac_en;
  logic [3:0] wb_alu0_idx, wb_alu1_idx, wb_mac_idx;
  logic [15:0] wb_alu0_data, wb_alu1_data, wb_mac_data, nbr_out;

  int errors = 0;
  int checks = 0;
  logic [15:0] m_rf [16];
  logic [31:0] m_acc;

  always #2.5 clk = ~clk;

  pe_dual_alu dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lane_op(int w, logic [3:0] op, int ua, int ub);
    int mask = (1 << w) - 1;
    int half = 1 << (w - 1);
    int sa = (ua >= half) ? ua - (1 << w) : ua;
    int sb = (ub >= half) ? ub - (1 << w) : ub;
    int sh = ub & (w - 1);
    case (op)
      4'd0:  return (ua + ub) & mask;
      4'd1:  return (ua - ub) & mask;
      4'd2:  return ua & ub;
      4'd3:  return ua | ub;
      4'd4:  return ua ^ ub;
      4'd5:  return (ua << sh) & mask;
      4'd6:  return ua >> sh;
      4'd7:  return (sa >>> sh) & mask;
      4'd8:  return (sa < sb) ? ua : ub;
      4'd9:  return (sa > sb) ? ua : ub;
      4'd10: return ((sa > sb) ? sa - sb : sb - sa) & mask;
      4'd12: return (sa < sb) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] m_alu(logic [3:0] op, logic bm,
                                       logic [15:0] a, logic [15:0] b);
    if (op == 4'd11) return nbr_in;
    if (!bm) return 16'(lane_op(16, op, int'(a), int'(b)));
    return {8'(lane_op(8, op, int'(a[15:8]), int'(b[15:8]))),
            8'(lane_op(8, op, int'(a[7:0]), int'(b[7:0])))};
  endfunction

  // one bundle: expectations from the model, edge, compare, model update
  task automatic fire();
    logic [15:0] e0, e1, em;
    logic [31:0] pr, an;
    logic go, gm, ga0, ga1;
    int sv;
    e0 = m_alu(alu0_op, byte_mode, m_rf[alu0_src_a], m_rf[alu0_src_b]);
    e1 = m_alu(alu1_op, byte_mode, m_rf[alu1_src_a], m_rf[alu1_src_b]);
    if (byte_mode)
      pr = 32'(int'($signed(m_rf[mac_src_a][7:0])) * int'($signed(m_rf[mac_src_b][7:0]))
             + int'($signed(m_rf[mac_src_a][15:8])) * int'($signed(m_rf[mac_src_b][15:8])));
    else
      pr = 32'(int'($signed(m_rf[mac_src_a])) * int'($signed(m_rf[mac_src_b])));
    an = mac_clr ? pr : m_acc + pr;
    sv = int'($signed(an));
    em = (sv > 32767) ? 16'h7FFF : (sv < -32768) ? 16'h8000 : an[15:0];
    go  = issue && pred;
    gm  = go && mac_en;
    ga0 = go && alu0_en && !(gm && mac_dst == alu0_dst);
    ga1 = go && alu1_en && !(gm && mac_dst == alu1_dst) && !(ga0 && alu0_dst == alu1_dst);
    @(posedge clk);
    @(negedge clk);
    chk(!go ? "R9" : (alu0_en && !ga0) ? "R8 alu0_en" : "R5 alu0_en", 32'(wb_alu0_en), 32'(ga0));
    chk(!go ? "R9" : (alu1_en && !ga1) ? "R8 alu1_en" : "R5 alu1_en", 32'(wb_alu1_en), 32'(ga1));
    chk(!go ? "R9 mac_en" : "R5 mac_en", 32'(wb_mac_en), 32'(gm));
    if (ga0) chk(alu0_op == 4'd11 ? "R4" : byte_mode ? "R3 alu0" : "R2 alu0",
                 32'(wb_alu0_data), 32'(e0));
    if (ga1) chk(alu1_op == 4'd11 ? "R4" : byte_mode ? "R3 alu1" : "R2 alu1",
                 32'(wb_alu1_data), 32'(e1));
    if (gm) chk((sv > 32767 || sv < -32768) ? "R7 sat" : "R6 acc", 32'(wb_mac_data), 32'(em));
    if (ga1) m_rf[alu1_dst] = e1;
    if (ga0) m_rf[alu0_dst] = e0;
    if (gm) begin m_rf[mac_dst] = em; m_acc = an; end
    chk("R10 nbr_out", 32'(nbr_out), 32'(m_rf[nbr_sel]));
  endtask

  task automatic idle();
    issue = 0; pred = 1; byte_mode = 0; alu0_en = 0; alu1_en = 0;
    mac_en = 0; mac_clr = 0; alu0_op = 0; alu1_op = 0; nbr_in = 0;
    alu0_dst = 0; alu0_src_a = 0; alu0_src_b = 0;
    alu1_dst = 0; alu1_src_a = 0; alu1_src_b = 0;
    mac_dst = 0; mac_src_a = 0; mac_src_b = 0; nbr_sel = 0;
  endtask

  task automatic load(logic [3:0] r, logic [15:0] v);
    idle(); issue = 1; alu0_en = 1; alu0_op = 4'd11; alu0_dst = r; nbr_in = v;
    nbr_sel = r; fire();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) m_rf[i] = '0;
    m_acc = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 wb_en", 32'({wb_alu0_en, wb_alu1_en, wb_mac_en}), 32'd0);
    for (int i = 0; i < 16; i++) begin
      nbr_sel = 4'(i); #1;
      chk("R1 reg", 32'(nbr_out), 32'd0);
    end
    // R1: accumulator zero: accumulate 0*0 reads back 0
    idle(); issue = 1; mac_en = 1; mac_dst = 4'd9; fire();

    // R4/R5: two moves in one cycle
    idle(); issue = 1; nbr_in = 16'h7FFF; alu0_en = 1; alu0_op = 4'd11; alu0_dst = 4'd1;
    alu1_en = 1; alu1_op = 4'd11; alu1_dst = 4'd2; fire();
    load(4'd2, 16'h8000);
    // R7: positive and negative saturation
    idle(); issue = 1; mac_en = 1; mac_clr = 1; mac_src_a = 1; mac_src_b = 1; mac_dst = 3; fire();
    idle(); issue = 1; mac_en = 1; mac_clr = 1; mac_src_a = 1; mac_src_b = 2; mac_dst = 3; fire();
    // R3: byte add 0x00FF + 0x0001 has no carry into the high lane
    load(4'd4, 16'h00FF); load(4'd5, 16'h0001);
    idle(); issue = 1; byte_mode = 1; alu0_en = 1; alu0_op = 4'd0;
    alu0_src_a = 4; alu0_src_b = 5; alu0_dst = 6; nbr_sel = 6; fire();
    // R8: three units at one register
    idle(); issue = 1; alu0_en = 1; alu1_en = 1; mac_en = 1; mac_clr = 1;
    alu0_src_a = 4; alu1_src_a = 5; mac_src_a = 5; mac_src_b = 5;
    alu0_dst = 7; alu1_dst = 7; mac_dst = 7; nbr_sel = 7; fire();
    // R9: predicate low with everything enabled; accumulator untouched afterwards
    idle(); issue = 1; pred = 0; alu0_en = 1; alu1_en = 1; mac_en = 1;
    alu0_dst = 1; alu1_dst = 2; mac_dst = 3; mac_src_a = 1; mac_src_b = 1; nbr_sel = 1; fire();
    idle(); issue = 1; mac_en = 1; mac_dst = 8; fire();

    // random mix with a small register pool
    for (int n = 0; n < 3000; n++) begin
      idle();
      issue = ($urandom % 8) != 0;
      pred = ($urandom % 6) != 0;
      byte_mode = $urandom % 2;
      alu0_en = $urandom % 2; alu1_en = $urandom % 2; mac_en = ($urandom % 3) == 0;
      mac_clr = ($urandom % 4) == 0;
      alu0_op = 4'($urandom); alu1_op = 4'($urandom);
      alu0_dst = 4'($urandom % 6); alu1_dst = 4'($urandom % 6); mac_dst = 4'($urandom % 6);
      alu0_src_a = 4'($urandom % 6); alu0_src_b = 4'($urandom % 6);
      alu1_src_a = 4'($urandom % 6); alu1_src_b = 4'($urandom % 6);
      mac_src_a = 4'($urandom % 6); mac_src_b = 4'($urandom % 6);
      nbr_in = 16'($urandom); nbr_sel = 4'($urandom % 6);
      fire();
    end
    finish_run();
  end
endmodule